// File: doc/BRIEF.md
# Hall-Sensor BLDC Commutation Controller

This block turns the three Hall sensor signals of a brushless DC motor into six gate-enable outputs for a three-phase N-channel half-bridge. Each phase has one high-side and one low-side enable. The filtered Hall code picks one phase to source current and one phase to sink it. A direction input swaps the two roles, so the motor turns the other way.

The high-side switch of the sourcing phase is chopped. It is on only while the external PWM command is high and no current-limit trip is latched. During the off time the low-side switch of that phase is turned on, which is synchronous rectification. A current-limit trip ends the present on-period. It stays in force until the next start of the fixed-frequency chopping cycle, which arrives as a one-cycle pulse. If the PWM command is held high and no trip occurs, the high side stays on continuously.

Every change of a phase from high to low, or from low to high, passes through an all-off gap of programmable length. The Hall code 000 is handled in one of two ways, chosen by a mode input: it either raises a fault with the bridge off, or it drives a fixed pre-position pattern. The code 111 always raises a fault. The Hall inputs are synchronised and glitch-filtered before they are decoded.

Top module: `bldc_commutator`

## Requirements
- R1: While `rst_n` is low, all six gate enables and `fault_o` are 0. Reset is asynchronous. After reset, `fault_o` stays 0 until the filter accepts its first Hall code.
- R2: Hall codes are read as {C,B,A} = `hall_i[2:0]`. Gate bit 0 is phase A, bit 1 is B and bit 2 is C. With `dir_rev_i`=0 the pairs (high, low) are:
  - 5 gives (A,B)
  - 4 gives (A,C)
  - 6 gives (B,C)
  - 2 gives (B,A)
  - 3 gives (C,A)
  - 1 gives (C,B)
- R3: With `dir_rev_i`=1, codes 1 to 6 give the same pair with the high and low phases swapped.
- R4: With `prepos_mode_i`=0, code 000 sets `fault_o`=1 and turns every gate enable off.
- R5: With `prepos_mode_i`=1, code 000 keeps `fault_o`=0 and drives phase A high, with B and C low, in either direction. The chopping of R7 and R9 applies to phase A.
- R6: Code 111 sets `fault_o`=1 and turns every gate enable off, whatever the mode.
- R7: While the high side of a driven phase is chopped off, the low side of that same phase is on (synchronous rectification). The sinking phase's low side stays on throughout.
- R8: With `pwm_cmd_i` held at 1 and no trip, the high side stays on in every cycle (100% duty).
- R9: A one-cycle `ilim_trip_i` pulse turns the high side off and keeps it off until a `cycle_start_i` pulse. After that pulse the high side is on again.
- R10: The high and low enables of one phase are never both 1. Neither can turn on in the cycle right after the other was on.
- R11: When a phase moves from high to low, both of its enables are off for exactly `dead_cycles_i`+1 clock cycles.
- R12: A Hall code change that lasts two cycles or less at `hall_i` is ignored, because the filter needs FILT_LEN=4 stable cycles. A change held longer is applied.
- R13: The dead-time input covers the full range 0 to 255. It gives an all-off gap of 1 cycle at 0 and 256 cycles at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, forces outputs off |
| hall_i | input | 3 | Raw Hall sensor levels {C,B,A} |
| pwm_cmd_i | input | 1 | External speed/torque PWM command |
| ilim_trip_i | input | 1 | Peak current-limit comparator flag |
| cycle_start_i | input | 1 | One-cycle pulse at each fixed-frequency chopping cycle start |
| dir_rev_i | input | 1 | 1 reverses the commutation sequence |
| prepos_mode_i | input | 1 | Handling of code 000: 0 = fault, 1 = pre-position |
| dead_cycles_i | input | 8 | Dead time in clock cycles |
| gate_hi_o | output | 3 | High-side enables, bit 0 = A |
| gate_lo_o | output | 3 | Low-side enables, bit 0 = A |
| fault_o | output | 1 | Invalid Hall code flag |

## Verification
The hardest case to reach from the ports is a dead-time gap bounded by its extremes. This is the full 256-cycle gap at a setting of 255, and the single-cycle gap at 0. The bench settles the bridge with a phase driven high, then drops the PWM command to force a high-to-low move. It counts the all-off cycles at each setting until the low side appears. The trip latch is also reached with timed pulses: a one-cycle trip is applied while the command is held high, and the bench confirms the high side stays off for many cycles until a cycle-start pulse arrives. Short Hall glitches are placed between accepted codes to show that the filter ignores them.

// File: rtl/bldc_pkg.sv
package bldc_pkg;

  localparam int NUM_PH = 3;

  typedef enum logic [1:0] {
    DRV_OFF = 2'd0,
    DRV_HI  = 2'd1,
    DRV_LO  = 2'd2
  } drv_e;

  typedef struct packed {
    logic [NUM_PH-1:0] hi;
    logic [NUM_PH-1:0] lo;
    logic              bad;
  } pair_t;

  // Hall code to source/sink phase selection; bit 0 = phase A.
  function automatic pair_t decode_hall(input logic [2:0] code,
                                        input logic rev,
                                        input logic prepos);
    pair_t r;
    r = '0;
    unique case (code)
      3'd5: begin r.hi = 3'b001; r.lo = 3'b010; end
      3'd4: begin r.hi = 3'b001; r.lo = 3'b100; end
      3'd6: begin r.hi = 3'b010; r.lo = 3'b100; end
      3'd2: begin r.hi = 3'b010; r.lo = 3'b001; end
      3'd3: begin r.hi = 3'b100; r.lo = 3'b001; end
      3'd1: begin r.hi = 3'b100; r.lo = 3'b010; end
      3'd0: begin
        if (prepos) begin r.hi = 3'b001; r.lo = 3'b110; end
        else r.bad = 1'b1;
      end
      default: r.bad = 1'b1;
    endcase
    if (rev && code != 3'd0 && !r.bad) begin
      r.hi = r.lo;
      r.lo = decode_hall(code, 1'b0, prepos).hi;
    end
    return r;
  endfunction

endpackage

// File: rtl/bldc_hall_filter.sv
module bldc_hall_filter #(
  parameter int W        = 3,
  parameter int FILT_LEN = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] code_o,
  output logic         valid_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [W-1:0]  s1_q, s2_q, cand_q, code_q;
  logic [CW-1:0] fcnt_q;
  logic          valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= '0;
      s2_q    <= '0;
      cand_q  <= '0;
      code_q  <= '0;
      fcnt_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q != cand_q) begin
        cand_q <= s2_q;
        fcnt_q <= '0;
      end else if (fcnt_q != CW'(FILT_LEN - 1)) begin
        fcnt_q <= fcnt_q + CW'(1);
      end else begin
        code_q  <= cand_q;
        valid_q <= 1'b1;
      end
    end
  end

  assign code_o  = code_q;
  assign valid_o = valid_q;

  // R12
  filt_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != $past(code_q)) |-> (code_q == cand_q && $past(s2_q) == code_q));

endmodule

// File: rtl/bldc_phase_gate.sv
module bldc_phase_gate
  import bldc_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  drv_e            req_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            hi_o,
  output logic            lo_o
);
  drv_e            st_q;
  logic [DT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DRV_OFF;
      cnt_q <= '0;
    end else if (req_i != st_q) begin
      if (st_q != DRV_OFF) begin
        st_q  <= DRV_OFF;
        cnt_q <= dead_i;
      end else if (cnt_q == '0) begin
        st_q <= req_i;
      end else begin
        cnt_q <= cnt_q - DT_W'(1);
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - DT_W'(1);
    end
  end

  assign hi_o = (st_q == DRV_HI);
  assign lo_o = (st_q == DRV_LO);

  // R10
  hi_then_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hi_o) |-> !lo_o);
  // R10
  lo_then_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lo_o) |-> !hi_o);

endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
  import bldc_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int DT_W     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      hall_i,
  input  logic            pwm_cmd_i,
  input  logic            ilim_trip_i,
  input  logic            cycle_start_i,
  input  logic            dir_rev_i,
  input  logic            prepos_mode_i,
  input  logic [DT_W-1:0] dead_cycles_i,
  output logic [2:0]      gate_hi_o,
  output logic [2:0]      gate_lo_o,
  output logic            fault_o
);
  logic [2:0] hall_f;
  logic       hall_ok;
  logic       chop_q;
  logic       on_req;
  pair_t      pair_raw, pair_eff;
  drv_e       req [NUM_PH];

  bldc_hall_filter #(.W(3), .FILT_LEN(FILT_LEN)) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   (hall_i),
    .code_o  (hall_f),
    .valid_o (hall_ok)
  );

  // Trip latch: a trip ends the on-period until the next cycle start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             chop_q <= 1'b0;
    else if (ilim_trip_i)   chop_q <= 1'b1;
    else if (cycle_start_i) chop_q <= 1'b0;
  end

  assign on_req   = pwm_cmd_i & ~chop_q;
  assign pair_raw = decode_hall(hall_f, dir_rev_i, prepos_mode_i);
  assign pair_eff = (hall_ok && !pair_raw.bad) ? pair_raw : '0;
  assign fault_o  = hall_ok & pair_raw.bad;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    always_comb begin
      if (pair_eff.hi[p])      req[p] = on_req ? DRV_HI : DRV_LO;
      else if (pair_eff.lo[p]) req[p] = DRV_LO;
      else                     req[p] = DRV_OFF;
    end

    bldc_phase_gate #(.DT_W(DT_W)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req[p]),
      .dead_i (dead_cycles_i),
      .hi_o   (gate_hi_o[p]),
      .lo_o   (gate_lo_o[p])
    );
  end

  // R4 R6
  fault_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault_o) |-> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000));
  // R9
  trip_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chop_q) |-> (gate_hi_o == 3'b000));

endmodule

// File: tb/bldc_commutator_bench.sv
module bldc_commutator_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall = 3'd5;
  logic       pwm = 1'b1, ilim = 1'b0, cstart = 1'b0, dir = 1'b0, mode = 1'b0;
  logic [7:0] dead = 8'd3;
  logic [2:0] ghi, glo;
  logic       flt;

  int checks = 0, fails = 0, overlaps = 0;

  always #10 clk = ~clk;

  bldc_commutator u_bldc_commutator (
    .clk(clk), .rst_n(rst_n), .hall_i(hall), .pwm_cmd_i(pwm),
    .ilim_trip_i(ilim), .cycle_start_i(cstart), .dir_rev_i(dir),
    .prepos_mode_i(mode), .dead_cycles_i(dead),
    .gate_hi_o(ghi), .gate_lo_o(glo), .fault_o(flt)
  );

  always @(negedge clk) if ((ghi & glo) != 3'b000) overlaps++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected steady drive: position p in forward order 5,4,6,2,3,1;
  // high phase = p/2, low phase = ((p+1)/2 + 1) mod 3.
  function automatic void expect_drive(input int code, input bit d, input bit m,
                                       input bit on, output int ehi,
                                       output int elo, output int ef);
    int p;
    int h, l, t;
    ehi = 0; elo = 0; ef = 0;
    case (code)
      5: p = 0; 4: p = 1; 6: p = 2; 2: p = 3; 3: p = 4; 1: p = 5;
      default: p = -1;
    endcase
    if (code == 7 || (code == 0 && !m)) begin
      ef = 1;
    end else if (code == 0) begin
      ehi = on ? 1 : 0;
      elo = on ? 6 : 7;
    end else begin
      h = p / 2;
      l = ((p + 1) / 2 + 1) % 3;
      if (d) begin t = h; h = l; l = t; end
      ehi = on ? (1 << h) : 0;
      elo = (1 << l) | (on ? 0 : (1 << h));
    end
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int ehi, elo, ef, gap, drops;
    wait_n(3);
    chk("R1 gate_hi in reset", int'(ghi), 0);
    chk("R1 gate_lo in reset", int'(glo), 0);
    chk("R1 fault in reset", int'(flt), 0);
    rst_n = 1'b1;
    wait_n(1);
    chk("R1 fault before first accept", int'(flt), 0);
    wait_n(30);

    // Sweep: mode x direction x pwm x code (R2 R3 R4 R5 R6 R7)
    for (int m = 0; m < 2; m++)
      for (int d = 0; d < 2; d++)
        for (int w = 0; w < 2; w++)
          for (int c = 0; c < 8; c++) begin
            mode = m[0]; dir = d[0]; pwm = w[0]; hall = c[2:0];
            wait_n(30);
            expect_drive(c, d[0], m[0], w[0], ehi, elo, ef);
            chk($sformatf("R2 R3 R5 R7 hi code=%0d dir=%0d mode=%0d pwm=%0d", c, d, m, w), int'(ghi), ehi);
            chk($sformatf("R2 R3 R5 R7 lo code=%0d dir=%0d mode=%0d pwm=%0d", c, d, m, w), int'(glo), elo);
            chk($sformatf("R4 R6 fault code=%0d mode=%0d", c, m), int'(flt), ef);
          end

    // R8: full duty
    mode = 0; dir = 0; pwm = 1; hall = 3'd5; dead = 8'd2;
    wait_n(30);
    drops = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ghi != 3'b001) drops++;
    end
    chk("R8 high side dropped cycles", drops, 0);

    // R9: trip latch held until cycle start
    ilim = 1'b1; wait_n(1); ilim = 1'b0;
    wait_n(10);
    chk("R9 hi off after trip", int'(ghi), 0);
    chk("R9 R7 lo on after trip", int'(glo), 3);
    wait_n(40);
    chk("R9 hi still off before cycle start", int'(ghi), 0);
    cstart = 1'b1; wait_n(1); cstart = 1'b0;
    wait_n(10);
    chk("R9 hi back after cycle start", int'(ghi), 1);
    chk("R9 lo after cycle start", int'(glo), 2);

    // R11 R13: dead-time gap length
    foreach (dead_set[k]) begin
      dead = dead_set[k];
      pwm = 1'b1;
      wait_n(int'(dead) + 20);
      pwm = 1'b0;
      gap = 0;
      for (int i = 0; i < 600 && glo[0] == 1'b0; i++) begin
        @(negedge clk);
        if (!ghi[0] && !glo[0]) gap++;
      end
      chk($sformatf("R11 R13 off gap dead=%0d", dead), gap, int'(dead) + 1);
      pwm = 1'b1;
    end

    // R12: glitch ignored, long change applied
    dead = 8'd2; pwm = 1'b1; hall = 3'd5;
    wait_n(30);
    drops = 0;
    hall = 3'd4; wait_n(2); hall = 3'd5;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (glo != 3'b010 || ghi != 3'b001) drops++;
    end
    chk("R12 two-cycle glitch disturbed outputs", drops, 0);
    hall = 3'd4;
    wait_n(30);
    chk("R12 held change lo", int'(glo), 4);

    // R1: reset mid-run forces off
    @(negedge clk); rst_n = 1'b0; #2;
    chk("R1 gate_hi on mid-run reset", int'(ghi), 0);
    chk("R1 gate_lo on mid-run reset", int'(glo), 0);
    wait_n(2); rst_n = 1'b1;
    wait_n(30);

    chk("R10 same-phase overlap cycles", overlaps, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  logic [7:0] dead_set [4] = '{8'd0, 8'd1, 8'd5, 8'd255};

endmodule